// File: doc/BRIEF.md
# Video Sync Period Measurement Unit

This unit measures the timing of an incoming video signal. It counts reference clocks across one horizontal period and horizontal periods across one vertical period. The horizontal source is picked from a bank of single-bit inputs, and the vertical sync arrives on its own input. All inputs are assumed to be synchronous to the reference clock already.

Software programs the unit through a small write port that has two registers: a control byte and a source selector. It can run the measurement continuously or request a single measurement. It can also hold the published results while measuring goes on, and it can limit result updates to odd fields of interlaced video. Each completed measurement toggles a polling flag, so a reader can tell when a new pair of counts has been committed.

A measurement window runs from one vertical event to the next. At the closing event the two counts and the polling flag change together in one clock edge. The counts then restart for the next window.

Top module: `sync_period_meter`

## Requirements
- R1: After reset, both result outputs are 0, the polling flag is 0, and every control bit and the source selector read 0.
- R2: In continuous mode (control bit 0 = 0) with the enable bit (control bit 4) set, each closing vertical event publishes the clock count of the last complete horizontal period and the number of horizontal rising edges in the window. With the enable bit clear, nothing is measured and the outputs do not change.
- R3: Control bit 3 picks the vertical event edge: 0 selects the rising edge of the vertical input and 1 selects the falling edge.
- R4: The selector (register address 1, bits 3:0) picks horizontal input code 0 to 12. Codes 13 to 15 select a constant low, so no horizontal edge is seen and the results are not updated.
- R5: In single mode (control bit 0 = 1), writing 1 to the start bit (control bit 1) arms one measurement. The first vertical event opens the window and the next one closes it. At the close the unit clears the start bit and measures nothing more.
- R6: In continuous mode, the freeze bit (control bit 2) makes closing events leave both results unchanged.
- R7: When the interlace bit (control bit 6), the odd-only bit (control bit 5) and the odd-indicator-present input are all 1, a closing event updates the results only if the odd-field input is 1. When the present input is 0, the field input has no effect.
- R8: Both counts saturate at all-ones and never wrap.
- R9: A horizontal edge in the same cycle as a vertical event counts toward the window that the event closes, and not toward the window it opens.
- R10: The polling flag toggles once for every closing vertical event, including events whose results are withheld by freeze, by the odd-only rule or by a reserved source.
- R11: A write to register address 0 loads control bits 6:0 from the write data. Both registers read back unchanged on their outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address: 0 control, 1 source selector |
| wr_data | input | 8 | Write data |
| hsrc_i | input | NUM_SRC | Candidate horizontal inputs |
| vsync_i | input | 1 | Vertical sync input |
| odd_field_i | input | 1 | Odd-field indicator |
| odd_present_i | input | 1 | High when the odd-field indicator is valid |
| hclk_count_o | output | CLK_W | Clocks per horizontal period |
| line_count_o | output | LINE_W | Horizontal periods per vertical period |
| poll_o | output | 1 | Toggles when a measurement completes |
| ctrl_o | output | 7 | Control register readback |
| src_sel_o | output | SEL_W | Source selector readback |

## Verification
A horizontal rising edge and a closing vertical event can land in the same clock. That one edge has to finish both the line count and the last period measurement, and it must not leak into the next window. The bench provokes this by placing each horizontal pulse on the first clock of its line, so every vertical edge coincides with a horizontal edge. The result passes only when the line count equals the programmed number of lines exactly and the period equals the programmed length.

// File: rtl/spm_pkg.sv
`timescale 1ns/1ps
package spm_pkg;
  localparam int CTRL_W = 7;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SRC  = 1'b1;

  // Bit 0 is at the bottom of the packed struct
  typedef struct packed {
    logic ilace;     // 6
    logic odd_only;  // 5
    logic fr_en;     // 4
    logic vneg;      // 3
    logic freeze;    // 2
    logic start;     // 1
    logic oneshot;   // 0
  } ctrl_t;
endpackage

// File: rtl/spm_rst_sync.sv
`timescale 1ns/1ps
module spm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/spm_regs.sv
`timescale 1ns/1ps
module spm_regs
  import spm_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             done_i,
  output ctrl_t            ctrl_o,
  output logic [SEL_W-1:0] sel_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             ctrl_wr, sel_wr, start_q;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    sel_wr  = wr_en && (wr_addr == ADDR_SRC);
    ctrl_d  = ctrl_q;
    sel_d   = sel_q;
    if (done_i)  ctrl_d.start = 1'b0;
    if (ctrl_wr) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (sel_wr)  sel_d  = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (ctrl_wr || done_i) ctrl_q <= ctrl_d;
      if (sel_wr)            sel_q  <= sel_d;
    end
  end

  assign start_q = ctrl_q.start;
  assign ctrl_o  = ctrl_q;
  assign sel_o   = sel_q;

  // R5: the start bit drops only at completion or by a write
  assert_start_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_q) |-> $past(done_i || (wr_en && wr_addr == ADDR_CTRL)));

  // R5: the start bit holds while no completion and no write occur
  assert_start_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !done_i && !(wr_en && wr_addr == ADDR_CTRL)) |=> start_q);
endmodule

// File: rtl/spm_src.sv
`timescale 1ns/1ps
module spm_src #(
  parameter int NUM_SRC = 13,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               vsync_i,
  input  logic               vneg_i,
  output logic               hedge_o,
  output logic               vevt_o
);
  localparam int NUM_CODES = 1 << SEL_W;

  logic [NUM_CODES-1:0] padded;
  logic                 sel_bit, h_prev_q, v_prev_q;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_pad
    if (g < NUM_SRC) begin : g_live
      assign padded[g] = src_i[g];
    end else begin : g_tie
      assign padded[g] = 1'b0;
    end
  end

  assign sel_bit = padded[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_prev_q <= 1'b0;
      v_prev_q <= 1'b0;
    end else begin
      h_prev_q <= sel_bit;
      v_prev_q <= vsync_i;
    end
  end

  always_comb begin
    hedge_o = sel_bit & ~h_prev_q;
    vevt_o  = vneg_i ? (v_prev_q & ~vsync_i) : (~v_prev_q & vsync_i);
  end

  // R2: a rising-edge detector never fires on two consecutive cycles
  assert_hedge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hedge_o |=> !hedge_o);

  // R4: a steady reserved code yields no horizontal events
  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i >= SEL_W'(NUM_SRC)) && $stable(sel_i)) |=> (!hedge_o || (sel_i < SEL_W'(NUM_SRC))));
endmodule

// File: rtl/spm_core.sv
`timescale 1ns/1ps
module spm_core
  import spm_pkg::*;
#(
  parameter int CLK_W  = 16,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hedge_i,
  input  logic              vevt_i,
  input  logic              odd_i,
  input  logic              odd_present_i,
  input  ctrl_t             ctrl_i,
  output logic              done_o,
  output logic [CLK_W-1:0]  hclk_o,
  output logic [LINE_W-1:0] lines_o,
  output logic              poll_o
);
  localparam logic [CLK_W-1:0]  CMAX = '1;
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic [CLK_W-1:0]  cnt_q, cnt_d, per_q, per_d, hclk_q, hclk_d, per_commit;
  logic [LINE_W-1:0] line_q, line_d, lines_q, lines_d, lines_commit;
  logic hseen_q, hseen_d, valid_q, valid_d, armed_q, armed_d, poll_q, poll_d;
  logic active, open_evt, close_evt, window_evt, valid_commit, hold_res, res_en;

  always_comb begin
    active     = ctrl_i.oneshot ? ctrl_i.start : ctrl_i.fr_en;
    open_evt   = active & vevt_i & ~armed_q;
    close_evt  = active & vevt_i & armed_q;
    window_evt = open_evt | close_evt;

    // clocks since the last horizontal edge, saturating
    cnt_d = hedge_i ? CLK_W'(1) : ((cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1);
    per_d = hedge_i ? cnt_q : per_q;

    // a coincident edge belongs to the closing window
    per_commit   = hedge_i ? cnt_q : per_q;
    lines_commit = (hedge_i && line_q != LMAX) ? line_q + 1'b1 : line_q;
    valid_commit = valid_q | (hedge_i & hseen_q);

    hseen_d = hseen_q;
    valid_d = valid_q;
    line_d  = line_q;
    if (window_evt) begin
      hseen_d = hedge_i;
      valid_d = 1'b0;
      line_d  = '0;
    end else if (hedge_i) begin
      hseen_d = 1'b1;
      valid_d = valid_q | hseen_q;
      if (armed_q && line_q != LMAX) line_d = line_q + 1'b1;
    end

    hold_res = (~ctrl_i.oneshot & ctrl_i.freeze)
             | (ctrl_i.ilace & ctrl_i.odd_only & odd_present_i & ~odd_i)
             | ~valid_commit;
    res_en  = close_evt & ~hold_res;
    hclk_d  = per_commit;
    lines_d = lines_commit;
    poll_d  = poll_q ^ close_evt;

    if (!active)                          armed_d = 1'b0;
    else if (open_evt)                    armed_d = 1'b1;
    else if (close_evt && ctrl_i.oneshot) armed_d = 1'b0;
    else                                  armed_d = armed_q;

    done_o = close_evt & ctrl_i.oneshot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      line_q  <= '0;
      hseen_q <= 1'b0;
      valid_q <= 1'b0;
      armed_q <= 1'b0;
      poll_q  <= 1'b0;
      hclk_q  <= '0;
      lines_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      line_q  <= line_d;
      hseen_q <= hseen_d;
      valid_q <= valid_d;
      armed_q <= armed_d;
      if (close_evt) poll_q <= poll_d;
      if (res_en) begin
        hclk_q  <= hclk_d;
        lines_q <= lines_d;
      end
    end
  end

  assign hclk_o  = hclk_q;
  assign lines_o = lines_q;
  assign poll_o  = poll_q;

  // R2: results move only on a cycle after a vertical event
  assert_result_on_vevt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hclk_q != $past(hclk_q) || lines_q != $past(lines_q)) |-> $past(vevt_i));

  // R6: a frozen closing event keeps results and still toggles the flag
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !ctrl_i.oneshot && ctrl_i.freeze) |=>
      ($stable(hclk_q) && $stable(lines_q) && (poll_q != $past(poll_q))));

  // R7: an even field under the odd-only rule leaves results unchanged
  assert_odd_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vevt_i && ctrl_i.ilace && ctrl_i.odd_only && odd_present_i && !odd_i) |=>
      ($stable(hclk_q) && $stable(lines_q)));

  // R8: saturated counters do not wrap
  assert_line_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == LMAX && !window_evt) |=> (line_q == LMAX));
  assert_clk_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !hedge_i) |=> (cnt_q == CMAX));

  // R10: the polling flag toggles only after a vertical event
  assert_poll_on_vevt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_q != $past(poll_q)) |-> $past(vevt_i));
endmodule

// File: rtl/sync_period_meter.sv
`timescale 1ns/1ps
module sync_period_meter
  import spm_pkg::*;
#(
  parameter int NUM_SRC = 13,
  parameter int SEL_W   = 4,
  parameter int CLK_W   = 16,
  parameter int LINE_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [NUM_SRC-1:0] hsrc_i,
  input  logic               vsync_i,
  input  logic               odd_field_i,
  input  logic               odd_present_i,
  output logic [CLK_W-1:0]   hclk_count_o,
  output logic [LINE_W-1:0]  line_count_o,
  output logic               poll_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [SEL_W-1:0]   src_sel_o
);
  logic             rst_ns, hedge, vevt, done;
  ctrl_t            ctrl;
  logic [SEL_W-1:0] sel;

  spm_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  spm_regs #(.SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done_i  (done),
    .ctrl_o  (ctrl),
    .sel_o   (sel)
  );

  spm_src #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_ns),
    .src_i   (hsrc_i),
    .sel_i   (sel),
    .vsync_i (vsync_i),
    .vneg_i  (ctrl.vneg),
    .hedge_o (hedge),
    .vevt_o  (vevt)
  );

  spm_core #(.CLK_W(CLK_W), .LINE_W(LINE_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_ns),
    .hedge_i       (hedge),
    .vevt_i        (vevt),
    .odd_i         (odd_field_i),
    .odd_present_i (odd_present_i),
    .ctrl_i        (ctrl),
    .done_o        (done),
    .hclk_o        (hclk_count_o),
    .lines_o       (line_count_o),
    .poll_o        (poll_o)
  );

  assign ctrl_o    = ctrl;
  assign src_sel_o = sel;
endmodule

// File: tb/sim_sync_period_meter.sv
`timescale 1ns/1ps
module sim_sync_period_meter;
  localparam int NSRC = 13;
  localparam int CW   = 8;
  localparam int LW   = 6;
  localparam int NV   = 5;

  // vector table: source, period, lines, falling-edge flag, expected period, expected lines
  localparam int    V_SRC[NV]  = '{0, 3, 12, 7, 5};
  localparam int    V_PER[NV]  = '{20, 37, 10, 300, 6};
  localparam int    V_NL[NV]   = '{5, 8, 12, 3, 70};
  localparam int    V_NEG[NV]  = '{0, 1, 0, 1, 0};
  localparam int    V_EP[NV]   = '{20, 37, 10, 255, 6};
  localparam int    V_EN[NV]   = '{5, 8, 12, 3, 63};
  localparam string V_TAG[NV]  = '{"R2", "R3", "R4", "R8", "R8"};

  logic            clk, rst_n, wr_en, wr_addr, vsync, odd_f, odd_p;
  logic [7:0]      wr_data;
  logic [NSRC-1:0] hsrc;
  logic [CW-1:0]   hclk_cnt;
  logic [LW-1:0]   line_cnt;
  logic            poll;
  logic [6:0]      ctrl_rb;
  logic [3:0]      sel_rb;

  int   n_chk, n_fail, toggles;
  logic poll_prev;
  bit   finished;

  sync_period_meter #(.NUM_SRC(NSRC), .SEL_W(4), .CLK_W(CW), .LINE_W(LW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .hsrc_i        (hsrc),
    .vsync_i       (vsync),
    .odd_field_i   (odd_f),
    .odd_present_i (odd_p),
    .hclk_count_o  (hclk_cnt),
    .line_count_o  (line_cnt),
    .poll_o        (poll),
    .ctrl_o        (ctrl_rb),
    .src_sel_o     (sel_rb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    toggles   = 0;
    poll_prev = 1'b0;
  end
  always @(negedge clk) begin
    if (poll !== poll_prev) toggles++;
    poll_prev = poll;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Frame f keeps vsync active for 3 + f*per cycles, so the two edges give different window lengths
  task automatic run_frames(input int src, input int per, input int nl,
                            input int vneg, input int hoff, input int nfr);
    for (int f = 0; f < nfr; f++)
      for (int l = 0; l < nl; l++)
        for (int c = 0; c < per; c++) begin
          @(negedge clk);
          vsync = logic'(vneg) ^ ((l * per + c) < (3 + f * per));
          hsrc  = '0;
          if (src < NSRC) hsrc[src] = (c == hoff);
          else            hsrc = {NSRC{c == hoff}};
        end
    @(negedge clk);
    vsync = logic'(vneg);
    hsrc  = '0;
  endtask

  // Continuous measurement with the given control extras
  task automatic measure(input int src, input int per, input int nl, input int vneg,
                         input int hoff, input logic [7:0] extra);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'(src));
    vsync = logic'(vneg);
    idle(3);
    wr(1'b0, 8'h10 | (vneg != 0 ? 8'h08 : 8'h00) | extra);
    run_frames(src, per, nl, vneg, hoff, 3);
    idle(3);
  endtask

  initial begin
    int t0;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    hsrc = '0; vsync = 1'b0; odd_f = 1'b0; odd_p = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk("R1 hclk", int'(hclk_cnt), 0);
    chk("R1 lines", int'(line_cnt), 0);
    chk("R1 poll", int'(poll), 0);
    chk("R1 ctrl", int'(ctrl_rb), 0);
    chk("R1 sel", int'(sel_rb), 0);

    // R11 register readback
    wr(1'b0, 8'h6C);
    chk("R11 ctrl", int'(ctrl_rb), 8'h6C);
    wr(1'b1, 8'h09);
    chk("R11 sel", int'(sel_rb), 9);
    wr(1'b0, 8'h00);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      t0 = toggles;
      measure(V_SRC[i], V_PER[i], V_NL[i], V_NEG[i], 2, 8'h00);
      chk({V_TAG[i], " period"}, int'(hclk_cnt), V_EP[i]);
      chk({V_TAG[i], " lines"}, int'(line_cnt), V_EN[i]);
      chk("R10 toggles", toggles - t0, 2);
    end

    // R2 enable bit clear: no measurement
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd0);
    t0 = toggles;
    run_frames(0, 20, 5, 0, 2, 3);
    idle(3);
    chk("R2 disabled period", int'(hclk_cnt), 6);
    chk("R2 disabled lines", int'(line_cnt), 63);
    chk("R2 disabled toggles", toggles - t0, 0);

    // R4 reserved code: all inputs pulse, results hold, flag still toggles
    t0 = toggles;
    measure(14, 20, 5, 0, 2, 8'h00);
    chk("R4 reserved period", int'(hclk_cnt), 6);
    chk("R4 reserved lines", int'(line_cnt), 63);
    chk("R10 reserved toggles", toggles - t0, 2);

    // R6 freeze, then release
    t0 = toggles;
    measure(2, 25, 9, 0, 2, 8'h04);
    chk("R6 frozen period", int'(hclk_cnt), 6);
    chk("R6 frozen lines", int'(line_cnt), 63);
    chk("R10 frozen toggles", toggles - t0, 2);
    measure(2, 25, 9, 0, 2, 8'h00);
    chk("R6 released period", int'(hclk_cnt), 25);
    chk("R6 released lines", int'(line_cnt), 9);

    // R9 horizontal edge coincident with every vertical event
    measure(1, 11, 6, 0, 0, 8'h00);
    chk("R9 period", int'(hclk_cnt), 11);
    chk("R9 lines", int'(line_cnt), 6);

    // R5 single measurement
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd4);
    vsync = 1'b0;
    idle(3);
    t0 = toggles;
    wr(1'b0, 8'h03);
    chk("R5 start set", int'(ctrl_rb), 8'h03);
    run_frames(4, 13, 4, 0, 2, 3);
    idle(3);
    chk("R5 start cleared", int'(ctrl_rb), 8'h01);
    chk("R5 period", int'(hclk_cnt), 13);
    chk("R5 lines", int'(line_cnt), 4);
    chk("R5 single toggle", toggles - t0, 1);

    // R7 odd-only rule
    odd_p = 1'b1; odd_f = 1'b0;
    t0 = toggles;
    measure(6, 17, 5, 0, 2, 8'h60);
    chk("R7 even period", int'(hclk_cnt), 13);
    chk("R7 even lines", int'(line_cnt), 4);
    chk("R7 even toggles", toggles - t0, 2);
    odd_f = 1'b1;
    measure(6, 17, 5, 0, 2, 8'h60);
    chk("R7 odd period", int'(hclk_cnt), 17);
    chk("R7 odd lines", int'(line_cnt), 5);
    odd_p = 1'b0; odd_f = 1'b0;
    measure(6, 19, 6, 0, 2, 8'h60);
    chk("R7 absent period", int'(hclk_cnt), 19);
    chk("R7 absent lines", int'(line_cnt), 6);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule